// File: doc/BRIEF.md
# Serial ADC Sample Deserializer

This block turns the serial output of a high-speed successive-approximation converter back into parallel samples. For every conversion, a clock-enable input gates a burst of the system clock out to the converter. The converter returns a data clock together with the sample bits, on one lane or on two lanes at once. The block captures those bits with that returned clock, rebuilds the sample and passes it into the system clock domain. There it appears on a parallel bus with a one-cycle strobe.

Resolution on the converter side and on the output side are separate parameters, each 16 or 18. A 16-bit result is sign-extended into an 18-bit output. An 18-bit result narrowed to 16 bits keeps its upper bits. A sink-ready input lets the block flag an overflow when a fresh sample lands on top of one that the sink has not taken yet.

Top module: `serial_adc_capture`

## Requirements
- R1: With `TWO_LANE`=1, one bit from each lane is taken on every rising edge of `dco`. `lane_a` carries word bits W-1, W-3, …, 1 and `lane_b` carries W-2, W-4, …, 0, MSB pair first. A word of W converter bits completes after W/2 rising edges.
- R2: With `TWO_LANE`=0, one `lane_a` bit is taken per rising edge of `dco`, MSB first, and a word completes after W edges. `lane_b` has no effect on any output.
- R3: With `ADC_BITS`=16 and `OUT_BITS`=18, output bits 17 and 16 both equal sample bit 15, and bits 15..0 equal the sample.
- R4: With `ADC_BITS`=18 and `OUT_BITS`=16, the output equals sample bits 17..2.
- R5: Each completed word raises `adc_valid` for exactly one `sys_clk` cycle, 2 to 5 `sys_clk` cycles after the last `dco` edge of the word. `adc_data` changes only in a cycle where `adc_valid` is high.
- R6: `adc_overflow` is high for one cycle, together with `adc_valid`, when a new sample is delivered while the previous one has been shown without `adc_ready` being high in any cycle since. It is never high in the cycle after a cycle with `adc_ready` high.
- R7: While `sys_clk` is high, `cnv_clk` equals the `clk_gate` value held during the preceding low phase. While `sys_clk` is low, `cnv_clk` is low.
- R8: While `rst_n` is low, `adc_valid`, `adc_overflow` and `adc_data` are zero. A partially received word is discarded, so the first full word after reset decodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock, source of the conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_gate | input | 1 | Enables the conversion clock burst |
| cnv_clk | output | 1 | Gated conversion clock to the converter |
| dco | input | 1 | Data clock returned by the converter |
| lane_a | input | 1 | Serial data, lane A |
| lane_b | input | 1 | Serial data, lane B (two-lane mode only) |
| adc_ready | input | 1 | Sink is taking the current sample |
| adc_valid | output | 1 | One-cycle strobe for a new sample |
| adc_data | output | OUT_BITS | Formatted parallel sample |
| adc_overflow | output | 1 | New sample arrived over an unread one |

## Verification
A bit counter that slips shows up at the ports as whole samples shifted by one or two bit positions, starting with the first word after the slip. The bench sees it as a data mismatch at that word's strobe. A broken toggle handshake shows up as a missing, doubled or late `adc_valid` within a few system cycles of a burst's last edge, and the cycle-by-cycle model catches it. A lost or stuck unread flag changes `adc_overflow` at the next delivered sample. A stuck clock-gate latch is visible in the very next high phase of `cnv_clk`.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  // Number of data-clock rising edges needed for one sample word.
  function automatic int word_edges(input int bits, input bit two_lane);
    return two_lane ? bits / 2 : bits;
  endfunction
endpackage

// File: rtl/rst_release.sv
// Asynchronous assertion, synchronous release of an active-low reset.
module rst_release (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;
endmodule

// File: rtl/clk_burst_gate.sv
// Latch-based clock gate: the enable is captured while the clock is low.
module clk_burst_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/serial_shifter.sv
// Data-clock domain: shifts lane bits in and publishes each finished word
// through a hold register plus a toggle flag.
module serial_shifter #(
  parameter int ADC_BITS = 16,
  parameter bit TWO_LANE = 1'b1
) (
  input  logic                dco,
  input  logic                rst_n,
  input  logic                lane_a,
  input  logic                lane_b,
  output logic [ADC_BITS-1:0] hold_word,
  output logic                word_tgl
);
  localparam int EDGES = adc_cap_pkg::word_edges(ADC_BITS, TWO_LANE);
  localparam int CW    = $clog2(EDGES);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic [ADC_BITS-1:0] shift_q, shift_d, shifted;
  logic [ADC_BITS-1:0] hold_q, hold_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                tgl_q, tgl_d;
  logic                word_done;

  generate
    if (TWO_LANE) begin : g_two
      assign shifted = {shift_q[ADC_BITS-3:0], lane_a, lane_b};
    end else begin : g_one
      logic unused_lane_b;
      assign unused_lane_b = lane_b;
      assign shifted = {shift_q[ADC_BITS-2:0], lane_a};
    end
  endgenerate

  always_comb begin
    word_done = (cnt_q == LAST);
    cnt_d     = word_done ? '0 : cnt_q + CW'(1);
    shift_d   = shifted;
    hold_d    = word_done ? shifted : hold_q;
    tgl_d     = tgl_q ^ word_done;
  end

  always_ff @(posedge dco or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      hold_q  <= '0;
      tgl_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      tgl_q   <= tgl_d;
      if (word_done) hold_q <= hold_d;
    end
  end

  assign hold_word = hold_q;
  assign word_tgl  = tgl_q;
endmodule

// File: rtl/word_sync.sv
// System-clock domain: synchronizes the toggle, detects a new word and
// registers the held word with a one-cycle valid.
module word_sync #(
  parameter int ADC_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tgl_in,
  input  logic [ADC_BITS-1:0] word_in,
  output logic                new_word,
  output logic                valid,
  output logic [ADC_BITS-1:0] word_out
);
  logic sync1_q, sync2_q, seen_q;
  logic valid_q, valid_d;
  logic [ADC_BITS-1:0] word_q, word_d;

  always_comb begin
    new_word = sync2_q ^ seen_q;
    valid_d  = new_word;
    word_d   = new_word ? word_in : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      sync1_q <= tgl_in;
      sync2_q <= sync1_q;
      seen_q  <= sync2_q;
      valid_q <= valid_d;
      if (new_word) word_q <= word_d;
    end
  end

  assign valid    = valid_q;
  assign word_out = word_q;
endmodule

// File: rtl/serial_adc_capture.sv
module serial_adc_capture #(
  parameter int ADC_BITS = 16,
  parameter int OUT_BITS = 18,
  parameter bit TWO_LANE = 1'b1
) (
  input  logic                sys_clk,
  input  logic                rst_n,
  input  logic                clk_gate,
  output logic                cnv_clk,
  input  logic                dco,
  input  logic                lane_a,
  input  logic                lane_b,
  input  logic                adc_ready,
  output logic                adc_valid,
  output logic [OUT_BITS-1:0] adc_data,
  output logic                adc_overflow
);
  logic                rst_n_sys;
  logic [ADC_BITS-1:0] hold_word;
  logic                word_tgl;
  logic                new_word;
  logic [ADC_BITS-1:0] word_q;
  logic                unread_q, unread_d;
  logic                ovf_q, ovf_d;

  rst_release u_rst (
    .clk       (sys_clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sys)
  );

  clk_burst_gate u_gate (
    .clk  (sys_clk),
    .en   (clk_gate),
    .gclk (cnv_clk)
  );

  serial_shifter #(.ADC_BITS(ADC_BITS), .TWO_LANE(TWO_LANE)) u_shift (
    .dco       (dco),
    .rst_n     (rst_n),
    .lane_a    (lane_a),
    .lane_b    (lane_b),
    .hold_word (hold_word),
    .word_tgl  (word_tgl)
  );

  word_sync #(.ADC_BITS(ADC_BITS)) u_sync (
    .clk      (sys_clk),
    .rst_n    (rst_n_sys),
    .tgl_in   (word_tgl),
    .word_in  (hold_word),
    .new_word (new_word),
    .valid    (adc_valid),
    .word_out (word_q)
  );

  // Unread tracking: a shown sample stays unread until adc_ready is seen.
  always_comb begin
    unread_d = (adc_valid | unread_q) & ~adc_ready;
    ovf_d    = new_word & (adc_valid | unread_q) & ~adc_ready;
  end

  always_ff @(posedge sys_clk or negedge rst_n_sys) begin
    if (!rst_n_sys) begin
      unread_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      unread_q <= unread_d;
      ovf_q    <= ovf_d;
    end
  end

  assign adc_overflow = ovf_q;

  generate
    if (OUT_BITS == ADC_BITS) begin : g_same
      assign adc_data = word_q;
    end else if (OUT_BITS > ADC_BITS) begin : g_sext
      assign adc_data = {{(OUT_BITS-ADC_BITS){word_q[ADC_BITS-1]}}, word_q};
    end else begin : g_trunc
      logic [ADC_BITS-OUT_BITS-1:0] unused_lsb;
      assign unused_lsb = word_q[ADC_BITS-OUT_BITS-1:0];
      assign adc_data   = word_q[ADC_BITS-1 -: OUT_BITS];
    end
  endgenerate
endmodule

// File: rtl/serial_adc_capture_chk.sv
module serial_adc_capture_chk #(
  parameter int ADC_BITS = 16,
  parameter int OUT_BITS = 18
) (
  input logic                sys_clk,
  input logic                rst_n,
  input logic                adc_ready,
  input logic                adc_valid,
  input logic [OUT_BITS-1:0] adc_data,
  input logic                adc_overflow
);
  assert_valid_pulse_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    adc_valid |=> !adc_valid);

  assert_data_hold_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !adc_valid |-> $stable(adc_data));

  assert_ovf_with_valid_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    adc_overflow |-> adc_valid);

  assert_no_overflow_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    adc_ready |=> !adc_overflow);

  generate
    if (OUT_BITS > ADC_BITS) begin : g_sext_chk
      assert_sign_ext_R3: assert property (@(posedge sys_clk) disable iff (!rst_n)
        adc_valid |-> (adc_data[OUT_BITS-1:ADC_BITS] ==
                       {(OUT_BITS-ADC_BITS){adc_data[ADC_BITS-1]}}));
    end
  endgenerate
endmodule

bind serial_adc_capture serial_adc_capture_chk #(
  .ADC_BITS(ADC_BITS),
  .OUT_BITS(OUT_BITS)
) u_chk (
  .sys_clk      (sys_clk),
  .rst_n        (rst_n),
  .adc_ready    (adc_ready),
  .adc_valid    (adc_valid),
  .adc_data     (adc_data),
  .adc_overflow (adc_overflow)
);

// File: tb/serial_adc_capture_bench.sv
module serial_adc_capture_bench;
  logic sys_clk = 1'b0;
  always #4 sys_clk = ~sys_clk;
  logic rst_n = 1'b0;

  // Instance 0: two lanes, 16-bit converter, 18-bit output
  logic g0 = 0, dco0 = 0, a0 = 0, b0 = 0, rdy0 = 0;
  logic cnv0, v0, o0;
  logic [17:0] d0;
  // Instance 1: one lane, 18-bit converter, 16-bit output
  logic g1 = 0, dco1 = 0, a1 = 0, b1 = 0, rdy1 = 0;
  logic cnv1, v1, o1;
  logic [15:0] d1;

  serial_adc_capture #(.ADC_BITS(16), .OUT_BITS(18), .TWO_LANE(1'b1)) u_serial_adc_capture (
    .sys_clk(sys_clk), .rst_n(rst_n), .clk_gate(g0), .cnv_clk(cnv0), .dco(dco0),
    .lane_a(a0), .lane_b(b0), .adc_ready(rdy0), .adc_valid(v0), .adc_data(d0),
    .adc_overflow(o0));

  serial_adc_capture #(.ADC_BITS(18), .OUT_BITS(16), .TWO_LANE(1'b0)) u_serial_adc_capture_1l (
    .sys_clk(sys_clk), .rst_n(rst_n), .clk_gate(g1), .cnv_clk(cnv1), .dco(dco1),
    .lane_a(a1), .lane_b(b1), .adc_ready(rdy1), .adc_valid(v1), .adc_data(d1),
    .adc_overflow(o1));

  int errors = 0;
  int checks = 0;
  int q0[$];
  int q1[$];
  bit pend0 = 0, pend1 = 0;
  int since0 = 100, since1 = 100;
  int ovf_seen0 = 0;
  int e0, e1;
  bit mon_on = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reference model, instance 0 (R1, R3, R5, R6)
  always @(negedge sys_clk) begin
    if (rst_n && mon_on) begin
      check(o0 == (v0 && pend0), "R6", "overflow0", o0, v0 && pend0);
      if (o0) ovf_seen0++;
      if (v0) begin
        if (q0.size() == 0) check(0, "R5", "unexpected valid0", 1, 0);
        else begin
          e0 = q0.pop_front();
          check(d0 == e0[17:0], "R1 R3", "data0", d0, e0);
          check(since0 >= 2 && since0 <= 5, "R5", "latency0", since0, 3);
        end
      end
      pend0 = (v0 || pend0) && !rdy0;
      since0++;
    end
  end

  // Reference model, instance 1 (R2, R4, R5)
  always @(negedge sys_clk) begin
    if (rst_n && mon_on) begin
      check(o1 == (v1 && pend1), "R6", "overflow1", o1, v1 && pend1);
      if (v1) begin
        if (q1.size() == 0) check(0, "R5", "unexpected valid1", 1, 0);
        else begin
          e1 = q1.pop_front();
          check(d1 == e1[15:0], "R2 R4", "data1", d1, e1);
          check(since1 >= 2 && since1 <= 5, "R5", "latency1", since1, 3);
        end
      end
      pend1 = (v1 || pend1) && !rdy1;
      since1++;
    end
  end

  // Clock gate checks (R7)
  always @(posedge sys_clk) begin
    #2;
    check(cnv0 === g0, "R7", "cnv0 high phase", cnv0, g0);
    check(cnv1 === g1, "R7", "cnv1 high phase", cnv1, g1);
  end
  always @(negedge sys_clk) begin
    #2;
    check(cnv0 === 1'b0, "R7", "cnv0 low phase", cnv0, 0);
  end

  // Watchdog
  always @(posedge sys_clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic send0(input int w);
    @(negedge sys_clk); #1 g0 = 1;
    for (int k = 0; k < 8; k++) begin
      a0 = w[15-2*k];
      b0 = w[14-2*k];
      #3 dco0 = 1;
      #3 dco0 = 0;
    end
    since0 = 0;
    q0.push_back(w[15] ? ((w & 'hFFFF) | 'h30000) : (w & 'hFFFF));
    @(negedge sys_clk); #1 g0 = 0;
    repeat (8) @(posedge sys_clk);
  endtask

  task automatic send1(input int w, input int junk);
    @(negedge sys_clk); #1 g1 = 1;
    for (int k = 0; k < 18; k++) begin
      a1 = w[17-k];
      b1 = junk[k];   // lane B must be ignored (R2)
      #3 dco1 = 1;
      #3 dco1 = 0;
    end
    since1 = 0;
    q1.push_back((w >> 2) & 'hFFFF);
    @(negedge sys_clk); #1 g1 = 0;
    repeat (8) @(posedge sys_clk);
  endtask

  task automatic set_rdy0(input logic v);
    @(posedge sys_clk); #1 rdy0 = v;
  endtask

  initial begin
    repeat (4) @(posedge sys_clk);
    #1;
    // R8: reset state
    check(v0 == 0 && o0 == 0, "R8", "ctrl0 in reset", {v0, o0}, 0);
    check(d0 == 0, "R8", "data0 in reset", d0, 0);
    check(v1 == 0 && d1 == 0, "R8", "inst1 in reset", d1, 0);
    @(posedge sys_clk); #1 rst_n = 1;
    repeat (4) @(posedge sys_clk);
    mon_on = 1;
    #1 rdy0 = 1; rdy1 = 1;

    // R1 and R3 patterns
    send0('h1234); send0('h8001); send0('hAAAA); send0('h5555);
    send0('hFFFF); send0('h7FFF); send0('h0000);
    // R2 and R4 patterns, with lane B garbage
    send1('h2A5C3, 'h3FFFF); send1('h3FFFF, 'h0); send1('h20001, 'h15555);
    send1('h15555, 'h2AAAA);

    // R6: two samples with sink not ready -> one overflow
    set_rdy0(0);
    send0('h1111); send0('h2222);
    check(ovf_seen0 == 1, "R6", "overflow count", ovf_seen0, 1);
    set_rdy0(1); repeat (2) @(posedge sys_clk);
    set_rdy0(0);
    send0('h3333);
    check(ovf_seen0 == 1, "R6", "no overflow after read", ovf_seen0, 1);
    set_rdy0(1); repeat (4) @(posedge sys_clk);

    // R8: reset in the middle of a burst
    @(negedge sys_clk); #1 g0 = 1;
    for (int k = 0; k < 5; k++) begin
      a0 = k[0]; b0 = ~k[0];
      #3 dco0 = 1;
      #3 dco0 = 0;
    end
    @(negedge sys_clk); #1 g0 = 0;
    @(posedge sys_clk); #1 rst_n = 0; mon_on = 0;
    repeat (3) @(posedge sys_clk);
    #1;
    check(v0 == 0 && d0 == 0, "R8", "data0 after mid reset", d0, 0);
    q0.delete(); pend0 = 0; pend1 = 0;
    @(posedge sys_clk); #1 rst_n = 1;
    repeat (4) @(posedge sys_clk);
    mon_on = 1;
    send0('h3C5A);
    send1('h0F0F0, 'h3FFFF);
    repeat (6) @(posedge sys_clk);
    check(q0.size() == 0, "R8", "word after reset delivered", q0.size(), 0);
    check(q1.size() == 0, "R5", "all words delivered", q1.size(), 0);
    summary();
  end
endmodule